// File: doc/BRIEF.md
# Self-Supplied Regulator Start-up Sequencer with Hiccup Fault Latch

This block sequences the supply of a self-powered switching regulator controller. Analog comparators report five conditions as digital flags: the high-voltage input is high enough to bias the charge generator, VCC has reached its turn-on level, VCC has sagged below its restart level, VCC has collapsed below its undervoltage level, and the sensed switch current has crossed the overcurrent level. From these flags the block drives two outputs. One enables the high-voltage charge current into the VCC capacitor. The other permits gate switching.

During start-up the charge generator fills the VCC capacitor until the turn-on level is reached. Switching then begins and the generator is turned off. While running, a sag below the restart level re-arms the generator, and it then charges only while the gate is off. The re-arm lasts until VCC is back at the turn-on level.

Overcurrent is filtered per switching cycle. A gate turn-on strobe marks where each cycle begins. A trip in one cycle only marks a warning. A trip in the next consecutive cycle latches a fault. The latched fault stops switching and starves the supply. Only an undervoltage collapse clears the latch, and the sequencer then waits for VCC to fall below the restart level before it charges again. The result is a slow hiccup pattern.

Top module: `supply_hiccup_seq`

## Requirements
- R1: A synchronous reset puts the block in the unpowered state: `hv_charge_en`, `switch_en` and `fault_latched` are all 0 on the clock after reset is sampled.
- R2: From the unpowered state, `hv_charge_en` rises on the clock after `hv_ok` is sampled high. While `hv_ok` is low, all outputs stay 0.
- R3: While charging, a sample of `vcc_on` high makes `switch_en` 1 and `hv_charge_en` 0 on the next clock.
- R4: While running, a sample of `vcc_rst_low` high arms recharge. While armed, `hv_charge_en` is 1 on the clock after each sample of `gate_off` high, and 0 after each sample of `gate_off` low. The arm is cleared by `vcc_on`.
- R5: A cycle with an overcurrent trip, followed by a cycle with no trip, clears the warning. A trip in the cycle after that does not latch a fault.
- R6: A trip in the cycle directly after a tripped cycle sets `fault_latched` to 1 and forces `switch_en` and `hv_charge_en` to 0 on the next clock. This includes a trip sampled on the turn-on strobe clock itself.
- R7: While the fault is latched and `vcc_uv` is low, the outputs stay at fault 1, switch 0 and charge 0, whatever the values of `hv_ok`, `vcc_on`, `vcc_rst_low`, `gate_start` and `gate_off`.
- R8: A sample of `vcc_uv` high clears `fault_latched` on the next clock. Charging then stays off until `vcc_rst_low` and `hv_ok` are both sampled high, and `hv_charge_en` rises on the clock after that.
- R9: Without a fault, a sample of `vcc_uv` high while running drops `switch_en` on the next clock. The block returns to charging (if `hv_ok` is high) or to the unpowered state (if it is low).
- R10: `oc_trip` is ignored outside the running state, and the strike history is cleared there.
- R11: An overcurrent pulse at any clock inside a cycle is held until the next `gate_start` strobe. That cycle counts as tripped even if the flag has since gone low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hv_ok | input | 1 | High-voltage input above the charge generator start level |
| vcc_on | input | 1 | VCC at or above the turn-on level |
| vcc_rst_low | input | 1 | VCC below the restart level |
| vcc_uv | input | 1 | VCC below the undervoltage level |
| oc_trip | input | 1 | Current sense above the overcurrent level |
| gate_start | input | 1 | One-clock strobe at each gate turn-on (start of a cycle) |
| gate_off | input | 1 | Gate is currently off |
| hv_charge_en | output | 1 | Registered enable for the high-voltage charge current |
| switch_en | output | 1 | Registered permission for gate switching |
| fault_latched | output | 1 | Registered overcurrent fault latch |

## Verification
Every output is registered, so a bad state register or strike counter becomes visible at the ports one clock after the input that exposes it. A strike count that is not cleared shows as a fault after a single trip. A count that never reaches its limit shows as switching that carries on after two tripped cycles. A latch that clears on the wrong flag shows up as a drop of `fault_latched` with `vcc_uv` low, or as charging that starts before `vcc_rst_low` is seen. A recharge arm that is handled badly shows as `hv_charge_en` out of step with `gate_off` within a clock.

// File: rtl/supply_seq_pkg.sv
package supply_seq_pkg;

   typedef enum logic [2:0] {
      SQ_OFF    = 3'd0,
      SQ_CHARGE = 3'd1,
      SQ_RUN    = 3'd2,
      SQ_FAULT  = 3'd3,
      SQ_HOLD   = 3'd4
   } seq_state_t;

endpackage

// File: rtl/seq_strike_filter.sv
// Counts consecutive tripped cycles; flags a fault on the trip that completes STRIKES.
module seq_strike_filter #(
   parameter int STRIKES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic active,
   input  logic cyc_strobe,
   input  logic oc_trip,
   output logic fault_hit
);
   localparam int CW = (STRIKES > 2) ? $clog2(STRIKES) : 1;
   localparam logic [CW-1:0] LIMIT = CW'(STRIKES - 1);

   if (STRIKES < 2) begin : g_bad_strikes
      $error("seq_strike_filter: STRIKES must be at least 2");
   end

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] prior;
   logic          hit_q;
   logic          trip_now;

   assign trip_now = active & oc_trip;

   // prior: number of consecutive tripped cycles completed before the current one
   always_comb begin
      if (cyc_strobe) begin
         if (!hit_q)              prior = '0;
         else if (cnt_q == LIMIT) prior = LIMIT;
         else                     prior = cnt_q + CW'(1);
      end else begin
         prior = cnt_q;
      end
   end

   assign fault_hit = trip_now && (prior == LIMIT);

   always_ff @(posedge clk) begin
      if (rst || !active) begin
         cnt_q <= '0;
         hit_q <= 1'b0;
      end else if (cyc_strobe) begin
         cnt_q <= prior;
         hit_q <= trip_now;
      end else begin
         hit_q <= hit_q | trip_now;
      end
   end
endmodule

// File: rtl/seq_state_ctl.sv
// Supply state machine with registered output decode.
module seq_state_ctl
   import supply_seq_pkg::*;
#(
   parameter bit OFFTIME_ONLY = 1'b1
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       hv_ok,
   input  logic       vcc_on,
   input  logic       vcc_rst_low,
   input  logic       vcc_uv,
   input  logic       gate_off,
   input  logic       fault_hit,
   output logic       running,
   output logic       hv_charge_en,
   output logic       switch_en,
   output logic       fault_latched
);
   seq_state_t st_q, st_n;
   logic       rech_q, rech_n;
   logic       window;

   if (OFFTIME_ONLY) begin : g_offtime
      assign window = gate_off;
   end else begin : g_anytime
      assign window = 1'b1;
   end

   assign running = (st_q == SQ_RUN);

   always_comb begin
      st_n = st_q;
      unique case (st_q)
         SQ_OFF:    if (hv_ok) st_n = SQ_CHARGE;
         SQ_CHARGE: begin
            if (!hv_ok)      st_n = SQ_OFF;
            else if (vcc_on) st_n = SQ_RUN;
         end
         SQ_RUN: begin
            if (fault_hit)   st_n = SQ_FAULT;
            else if (vcc_uv) st_n = hv_ok ? SQ_CHARGE : SQ_OFF;
         end
         SQ_FAULT:  if (vcc_uv) st_n = SQ_HOLD;
         SQ_HOLD:   if (vcc_rst_low && hv_ok) st_n = SQ_CHARGE;
         default:   st_n = SQ_OFF;
      endcase
   end

   always_comb begin
      if (st_n != SQ_RUN) rech_n = 1'b0;
      else if (vcc_on)    rech_n = 1'b0;
      else if (vcc_rst_low) rech_n = 1'b1;
      else                rech_n = rech_q;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q          <= SQ_OFF;
         rech_q        <= 1'b0;
         hv_charge_en  <= 1'b0;
         switch_en     <= 1'b0;
         fault_latched <= 1'b0;
      end else begin
         st_q          <= st_n;
         rech_q        <= rech_n;
         hv_charge_en  <= (st_n == SQ_CHARGE) ||
                          ((st_n == SQ_RUN) && rech_n && window && hv_ok);
         switch_en     <= (st_n == SQ_RUN);
         fault_latched <= (st_n == SQ_FAULT);
      end
   end
endmodule

// File: rtl/supply_hiccup_seq.sv
module supply_hiccup_seq #(
   parameter int STRIKES      = 2,
   parameter bit OFFTIME_ONLY = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic hv_ok,
   input  logic vcc_on,
   input  logic vcc_rst_low,
   input  logic vcc_uv,
   input  logic oc_trip,
   input  logic gate_start,
   input  logic gate_off,
   output logic hv_charge_en,
   output logic switch_en,
   output logic fault_latched
);
   logic running;
   logic fault_hit;

   seq_strike_filter #(.STRIKES(STRIKES)) u_filter (
      .clk        (clk),
      .rst        (rst),
      .active     (running),
      .cyc_strobe (gate_start),
      .oc_trip    (oc_trip),
      .fault_hit  (fault_hit)
   );

   seq_state_ctl #(.OFFTIME_ONLY(OFFTIME_ONLY)) u_ctl (
      .clk           (clk),
      .rst           (rst),
      .hv_ok         (hv_ok),
      .vcc_on        (vcc_on),
      .vcc_rst_low   (vcc_rst_low),
      .vcc_uv        (vcc_uv),
      .gate_off      (gate_off),
      .fault_hit     (fault_hit),
      .running       (running),
      .hv_charge_en  (hv_charge_en),
      .switch_en     (switch_en),
      .fault_latched (fault_latched)
   );
endmodule

// File: rtl/supply_hiccup_seq_chk.sv
module supply_hiccup_seq_chk #(
   parameter bit OFFTIME_ONLY = 1'b1
) (
   input logic clk,
   input logic rst,
   input logic hv_ok,
   input logic vcc_on,
   input logic vcc_uv,
   input logic gate_off,
   input logic hv_charge_en,
   input logic switch_en,
   input logic fault_latched
);
   // R1
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> (!hv_charge_en && !switch_en && !fault_latched));

   // R6
   fault_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      fault_latched |-> (!switch_en && !hv_charge_en));

   // R8
   latch_clear_uv_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(fault_latched) |-> $past(vcc_uv));

   // R3
   switch_start_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(switch_en) |-> $past(vcc_on));

   // R2
   charge_needs_hv_chk: assert property (@(posedge clk) disable iff (rst)
      hv_charge_en |-> $past(hv_ok));

   // R4
   recharge_offtime_chk: assert property (@(posedge clk) disable iff (rst)
      (OFFTIME_ONLY && switch_en && hv_charge_en) |-> $past(gate_off));
endmodule

bind supply_hiccup_seq supply_hiccup_seq_chk #(.OFFTIME_ONLY(OFFTIME_ONLY)) u_chk (
   .clk           (clk),
   .rst           (rst),
   .hv_ok         (hv_ok),
   .vcc_on        (vcc_on),
   .vcc_uv        (vcc_uv),
   .gate_off      (gate_off),
   .hv_charge_en  (hv_charge_en),
   .switch_en     (switch_en),
   .fault_latched (fault_latched)
);

// File: tb/supply_hiccup_seq_test.sv
module supply_hiccup_seq_test;
   logic clk = 1'b0;
   logic rst, hv_ok, vcc_on, vcc_rst_low, vcc_uv, oc_trip, gate_start, gate_off;
   logic hv_charge_en, switch_en, fault_latched;

   int n_vec  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   logic [2:0] exp_q[$];   // {switch_en, hv_charge_en, fault_latched}
   string      tag_q[$];

   always #4 clk = ~clk;

   supply_hiccup_seq uut (
      .clk(clk), .rst(rst), .hv_ok(hv_ok), .vcc_on(vcc_on),
      .vcc_rst_low(vcc_rst_low), .vcc_uv(vcc_uv), .oc_trip(oc_trip),
      .gate_start(gate_start), .gate_off(gate_off),
      .hv_charge_en(hv_charge_en), .switch_en(switch_en),
      .fault_latched(fault_latched)
   );

   // driver: apply one input set per clock and queue the outputs expected after that edge
   task automatic step(input logic r, input logic hv, input logic von, input logic rl,
                       input logic uv, input logic oc, input logic gs, input logic go,
                       input logic [2:0] exp, input string tag);
      @(negedge clk);
      rst = r; hv_ok = hv; vcc_on = von; vcc_rst_low = rl; vcc_uv = uv;
      oc_trip = oc; gate_start = gs; gate_off = go;
      exp_q.push_back(exp);
      tag_q.push_back(tag);
   endtask

   // monitor: compare after each rising edge
   always @(posedge clk) begin
      #1;
      if (exp_q.size() > 0) begin
         logic [2:0] e;
         logic [2:0] a;
         string      t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         a = {switch_en, hv_charge_en, fault_latched};
         n_vec++;
         if (a !== e) begin
            n_fail++;
            $display("FAIL %s: {sw,chg,flt} actual %b expected %b", t, a, e);
         end
      end
   end

   initial begin
      rst = 1; hv_ok = 0; vcc_on = 0; vcc_rst_low = 1; vcc_uv = 1;
      oc_trip = 0; gate_start = 0; gate_off = 1;
      //    rst hv von rl uv oc gs go  {sw,chg,flt}
      step(1, 0, 0, 1, 1, 0, 0, 1, 3'b000, "R1 reset");
      step(1, 1, 1, 0, 0, 1, 1, 1, 3'b000, "R1 reset under activity");
      step(0, 0, 0, 1, 1, 0, 0, 1, 3'b000, "R2 no hv");
      step(0, 0, 1, 1, 1, 1, 0, 1, 3'b000, "R2 no hv with flags");
      step(0, 1, 0, 1, 1, 1, 1, 1, 3'b010, "R2/R10 start charge, trip ignored");
      step(0, 1, 0, 1, 1, 1, 1, 1, 3'b010, "R10 trip ignored while charging");
      step(0, 1, 1, 0, 0, 0, 0, 1, 3'b100, "R3 turn-on level reached");
      step(0, 1, 0, 0, 0, 0, 0, 1, 3'b100, "R4 running, no recharge");
      step(0, 1, 0, 1, 0, 0, 0, 1, 3'b110, "R4 sag arms recharge in off-time");
      step(0, 1, 0, 0, 0, 0, 0, 0, 3'b100, "R4 gate on blocks charge");
      step(0, 1, 0, 0, 0, 0, 0, 1, 3'b110, "R4 arm held into off-time");
      step(0, 1, 1, 0, 0, 0, 0, 1, 3'b100, "R4 turn-on level clears arm");
      step(0, 1, 0, 0, 0, 0, 0, 1, 3'b100, "R4 arm stays cleared");
      // cycle A tripped by a short pulse, cycle B clean, cycle C tripped
      step(0, 1, 0, 0, 0, 0, 1, 0, 3'b100, "R11 cycle A start");
      step(0, 1, 0, 0, 0, 1, 0, 0, 3'b100, "R11 pulse in cycle A");
      step(0, 1, 0, 0, 0, 0, 0, 1, 3'b100, "R11 pulse gone");
      step(0, 1, 0, 0, 0, 0, 1, 0, 3'b100, "R5 cycle B start");
      step(0, 1, 0, 0, 0, 0, 0, 1, 3'b100, "R5 cycle B clean");
      step(0, 1, 0, 0, 0, 0, 1, 0, 3'b100, "R5 cycle C start");
      step(0, 1, 0, 0, 0, 1, 0, 0, 3'b100, "R5 trip after clean cycle, no fault");
      step(0, 1, 0, 0, 0, 0, 1, 0, 3'b100, "R11/R6 cycle D start");
      step(0, 1, 0, 0, 0, 1, 0, 0, 3'b001, "R6 second consecutive trip latches");
      step(0, 1, 1, 1, 0, 0, 1, 1, 3'b001, "R7 latch holds vs turn-on/restart");
      step(0, 0, 0, 1, 0, 1, 0, 1, 3'b001, "R7 latch holds vs hv low");
      step(0, 1, 0, 1, 0, 0, 1, 0, 3'b001, "R7 latch holds");
      step(0, 1, 0, 0, 1, 0, 0, 1, 3'b000, "R8 undervoltage clears latch");
      step(0, 1, 0, 0, 1, 0, 0, 1, 3'b000, "R8 wait for restart level");
      step(0, 0, 0, 1, 1, 0, 0, 1, 3'b000, "R8 restart level but no hv");
      step(0, 1, 0, 1, 1, 0, 0, 1, 3'b010, "R8 recharge begins");
      step(0, 1, 1, 0, 0, 0, 0, 1, 3'b100, "R3 running again");
      step(0, 1, 0, 0, 1, 0, 0, 1, 3'b010, "R9 undervoltage while running");
      step(0, 1, 1, 0, 0, 0, 0, 1, 3'b100, "R3 running once more");
      step(0, 0, 0, 0, 1, 0, 0, 1, 3'b000, "R9 undervoltage with hv low");
      step(0, 1, 0, 1, 1, 0, 0, 1, 3'b010, "R2 charge from unpowered");
      step(0, 1, 1, 0, 0, 0, 0, 1, 3'b100, "R3 running");
      step(0, 1, 0, 0, 0, 0, 1, 0, 3'b100, "R6 cycle E start");
      step(0, 1, 0, 0, 0, 1, 0, 0, 3'b100, "R6 trip in cycle E");
      step(0, 1, 0, 0, 0, 1, 1, 0, 3'b001, "R6 trip on strobe of cycle F");
      step(0, 1, 0, 0, 0, 0, 0, 1, 3'b001, "R7 latch holds");
      step(0, 1, 0, 0, 0, 0, 0, 1, 3'b001, "R7 latch holds");
      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
   end

   initial begin
      int cyc = 0;
      while (!done && cyc < 5000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run hung, actual incomplete expected done");
      end
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end
endmodule